// File: doc/BRIEF.md
# Acknowledged Retransmission Link Controller

This block holds both ends of a positive-acknowledgement link over a packet channel that may lose frames. A client hands the send side one message at a time. The request carries a destination node, a message ID that the client chose, a broadcast flag, a retransmission allowance and a minimum pause between attempts. The send side puts the frame on a shared transmit port. It then waits a configurable number of cycles for an acknowledgement that matches both the destination and the ID. If none arrives, it waits out the pause and tries again. When the allowance runs out, it reports an error. A broadcast goes out once and finishes at once, because no node acknowledges it.

The receive side takes every data frame that the channel delivers. It answers each one with an acknowledgement to the frame's source. Its client sees a message only when that source has not already had that ID accepted. A lost acknowledgement therefore causes a resend at the far end but never a second delivery. Frames travel as parallel words with valid strobes. Checksums, the physical layer and ID allocation belong to the surrounding system.

Top module: `parl_link_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, `req_ready` is 1 and `tx_valid`, `done_valid` and `dlv_valid` are 0.
- R2: A request is taken in a cycle where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the cycle in which `done_valid` pulses for one cycle, and `done_err` is valid in that cycle.
- R3: A data frame appears on the transmit port with `tx_kind`=0 and with the request's destination, ID and payload. A frame shown while `tx_ready` is low is held unchanged until it is taken.
- R4: A broadcast request is transmitted exactly once. It completes with `done_err`=0 once the channel takes the frame, without waiting for any acknowledgement.
- R5: A unicast attempt is answered by an incoming frame with `rx_kind`=1, `rx_src` equal to the destination and `rx_id` equal to the message ID. If that frame arrives within `cfg_ack_timeout`+1 cycles after the channel takes the attempt, the request completes with `done_err`=0 and nothing more is transmitted.
- R6: An acknowledgement with a different ID or from a different source has no effect on the outstanding request.
- R7: If no matching acknowledgement arrives in time, the frame is resent. A request with allowance N makes at most N+1 attempts. If all of them go unanswered, it completes with `done_err`=1.
- R8: Two attempts of one message are taken by the channel at least `cfg_ack_timeout` + `req_gap` + 3 cycles apart.
- R9: Every data frame (`rx_kind`=0) that arrives while no acknowledgement is pending is answered with a frame of `tx_kind`=1, `tx_dest`=`rx_src` and `tx_id`=`rx_id`. A pending acknowledgement wins the transmit port over a data frame that is not already on the port.
- R10: A received data frame is passed to the client, with a one-cycle `dlv_valid` pulse in the next cycle, only if its ID differs from the last ID accepted from that source or if that source has sent nothing yet. Each source is tracked on its own.
- R11: A data frame that arrives while an acknowledgement is still waiting for the transmit port is neither acknowledged nor delivered, and it does not change the duplicate record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Send request strobe |
| req_ready | output | 1 | Send side idle, request can be taken |
| req_dest | input | ADDR_W | Destination node |
| req_id | input | ID_W | Client-chosen message ID |
| req_bcast | input | 1 | Broadcast: send once, expect no acknowledgement |
| req_payload | input | PAY_W | Message payload |
| req_retries | input | RTY_W | Retransmissions allowed after the first attempt |
| req_gap | input | GAP_W | Minimum pause cycles after a timeout |
| cfg_ack_timeout | input | TMO_W | Acknowledgement wait, held stable during a request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a failure (valid with done_valid) |
| tx_valid | output | 1 | Frame offered to the channel |
| tx_ready | input | 1 | Channel takes the offered frame |
| tx_kind | output | 1 | 0 data, 1 acknowledgement |
| tx_dest | output | ADDR_W | Frame destination |
| tx_id | output | ID_W | Frame message ID |
| tx_payload | output | PAY_W | Frame payload (zero for acknowledgements) |
| rx_valid | input | 1 | Incoming frame strobe |
| rx_kind | input | 1 | 0 data, 1 acknowledgement |
| rx_src | input | ADDR_W | Sending node |
| rx_id | input | ID_W | Frame message ID |
| rx_payload | input | PAY_W | Frame payload |
| dlv_valid | output | 1 | New message for the client |
| dlv_src | output | ADDR_W | Source of the delivered message |
| dlv_id | output | ID_W | ID of the delivered message |
| dlv_payload | output | PAY_W | Delivered payload |

## Verification
A corrupted attempt counter or timer in the send side shows up at the transmit port within one acknowledgement window. The symptom is an attempt count that differs from the allowance, spacing between resends that is shorter than expected, or a completion whose error flag is wrong. A stale or wrongly indexed entry in the duplicate record shows up on the very next frame from that source, as a missing or repeated `dlv_valid`. A fault in the pending-acknowledgement state shows up in the cycle after a data frame arrives: an acknowledgement that is missing, misaddressed or duplicated, or a data frame that overtakes it.

// File: rtl/parl_pkg.sv
package parl_pkg;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_XMIT,
        SND_WAIT,
        SND_GAP
    } snd_state_e;

    localparam logic KIND_DATA = 1'b0;
    localparam logic KIND_ACK  = 1'b1;

endpackage

// File: rtl/parl_sender.sv
module parl_sender
    import parl_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 16,
    parameter int RTY_W  = 4,
    parameter int GAP_W  = 6,
    parameter int TMO_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_dest,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_bcast,
    input  logic [PAY_W-1:0]  req_payload,
    input  logic [RTY_W-1:0]  req_retries,
    input  logic [GAP_W-1:0]  req_gap,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_src,
    input  logic [ID_W-1:0]   ack_id,
    output logic              dat_valid,
    input  logic              dat_grant,
    output logic [ADDR_W-1:0] dat_dest,
    output logic [ID_W-1:0]   dat_id,
    output logic [PAY_W-1:0]  dat_payload,
    output logic              done_valid,
    output logic              done_err
);

    localparam int CNT_W = (GAP_W > TMO_W) ? GAP_W : TMO_W;

    typedef struct packed {
        snd_state_e        st;
        logic [ADDR_W-1:0] dest;
        logic [ID_W-1:0]   id;
        logic              bcast;
        logic [PAY_W-1:0]  payload;
        logic [RTY_W-1:0]  left;
        logic [GAP_W-1:0]  gap;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              err;
    } snd_t;

    snd_t snd_q, snd_d;

    logic ack_match;
    assign ack_match = ack_valid && (ack_id == snd_q.id) && (ack_src == snd_q.dest);

    always_comb begin
        snd_d      = snd_q;
        snd_d.done = 1'b0;
        case (snd_q.st)
            SND_IDLE: begin
                if (req_valid) begin
                    snd_d.st      = SND_XMIT;
                    snd_d.dest    = req_dest;
                    snd_d.id      = req_id;
                    snd_d.bcast   = req_bcast;
                    snd_d.payload = req_payload;
                    snd_d.left    = req_retries;
                    snd_d.gap     = req_gap;
                    snd_d.cnt     = '0;
                    snd_d.err     = 1'b0;
                end
            end
            SND_XMIT: begin
                if (dat_grant) begin
                    if (snd_q.bcast) begin
                        snd_d.st   = SND_IDLE;
                        snd_d.done = 1'b1;
                        snd_d.err  = 1'b0;
                    end else begin
                        snd_d.st  = SND_WAIT;
                        snd_d.cnt = '0;
                    end
                end
            end
            SND_WAIT: begin
                if (ack_match) begin
                    snd_d.st   = SND_IDLE;
                    snd_d.done = 1'b1;
                    snd_d.err  = 1'b0;
                end else if (snd_q.cnt == CNT_W'(cfg_timeout)) begin
                    if (snd_q.left == '0) begin
                        snd_d.st   = SND_IDLE;
                        snd_d.done = 1'b1;
                        snd_d.err  = 1'b1;
                    end else begin
                        snd_d.left = snd_q.left - 1'b1;
                        snd_d.st   = SND_GAP;
                        snd_d.cnt  = '0;
                    end
                end else begin
                    snd_d.cnt = snd_q.cnt + 1'b1;
                end
            end
            SND_GAP: begin
                if (snd_q.cnt == CNT_W'(snd_q.gap)) begin
                    snd_d.st = SND_XMIT;
                end else begin
                    snd_d.cnt = snd_q.cnt + 1'b1;
                end
            end
            default: snd_d.st = SND_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snd_q <= '0;
        end else begin
            snd_q <= snd_d;
        end
    end

    assign req_ready   = (snd_q.st == SND_IDLE);
    assign dat_valid   = (snd_q.st == SND_XMIT);
    assign dat_dest    = snd_q.dest;
    assign dat_id      = snd_q.id;
    assign dat_payload = snd_q.payload;
    assign done_valid  = snd_q.done;
    assign done_err    = snd_q.err;

endmodule

// File: rtl/parl_dup_table.sv
module parl_dup_table #(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_src,
    input  logic [ID_W-1:0]   lk_id,
    output logic              lk_new,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_src,
    input  logic [ID_W-1:0]   wr_id
);

    localparam int NODES = 1 << ADDR_W;

    logic [NODES-1:0] seen_vec;
    logic [ID_W-1:0]  last_arr [NODES];

    for (genvar g = 0; g < NODES; g++) begin : g_entry
        typedef struct packed {
            logic            seen;
            logic [ID_W-1:0] last;
        } ent_t;

        ent_t ent_q, ent_d;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_src == ADDR_W'(g))) begin
                ent_d.seen = 1'b1;
                ent_d.last = wr_id;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign seen_vec[g] = ent_q.seen;
        assign last_arr[g] = ent_q.last;
    end

    assign lk_new = !seen_vec[lk_src] || (last_arr[lk_src] != lk_id);

endmodule

// File: rtl/parl_receiver.sv
module parl_receiver #(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ADDR_W-1:0] frm_src,
    input  logic [ID_W-1:0]   frm_id,
    input  logic [PAY_W-1:0]  frm_payload,
    output logic              ack_valid,
    input  logic              ack_grant,
    output logic [ADDR_W-1:0] ack_dest,
    output logic [ID_W-1:0]   ack_id,
    output logic              dlv_valid,
    output logic [ADDR_W-1:0] dlv_src,
    output logic [ID_W-1:0]   dlv_id,
    output logic [PAY_W-1:0]  dlv_payload
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] adest;
        logic [ID_W-1:0]   aid;
        logic              dlv;
        logic [ADDR_W-1:0] dsrc;
        logic [ID_W-1:0]   did;
        logic [PAY_W-1:0]  dpay;
    } rcv_t;

    rcv_t rcv_q, rcv_d;
    logic is_new;
    logic take;
    logic record;

    assign take   = frm_valid && !rcv_q.pend;
    assign record = take && is_new;

    parl_dup_table #(
        .ID_W  (ID_W),
        .ADDR_W(ADDR_W)
    ) u_dup (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_src(frm_src),
        .lk_id (frm_id),
        .lk_new(is_new),
        .wr_en (record),
        .wr_src(frm_src),
        .wr_id (frm_id)
    );

    always_comb begin
        rcv_d     = rcv_q;
        rcv_d.dlv = 1'b0;
        if (rcv_q.pend && ack_grant) begin
            rcv_d.pend = 1'b0;
        end
        if (take) begin
            rcv_d.pend  = 1'b1;
            rcv_d.adest = frm_src;
            rcv_d.aid   = frm_id;
            if (is_new) begin
                rcv_d.dlv  = 1'b1;
                rcv_d.dsrc = frm_src;
                rcv_d.did  = frm_id;
                rcv_d.dpay = frm_payload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcv_q <= '0;
        end else begin
            rcv_q <= rcv_d;
        end
    end

    assign ack_valid   = rcv_q.pend;
    assign ack_dest    = rcv_q.adest;
    assign ack_id      = rcv_q.aid;
    assign dlv_valid   = rcv_q.dlv;
    assign dlv_src     = rcv_q.dsrc;
    assign dlv_id      = rcv_q.did;
    assign dlv_payload = rcv_q.dpay;

endmodule

// File: rtl/parl_tx_arb.sv
module parl_tx_arb
    import parl_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_dest,
    input  logic [ID_W-1:0]   ack_id,
    output logic              ack_grant,
    input  logic              dat_valid,
    input  logic [ADDR_W-1:0] dat_dest,
    input  logic [ID_W-1:0]   dat_id,
    input  logic [PAY_W-1:0]  dat_payload,
    output logic              dat_grant,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_kind,
    output logic [ADDR_W-1:0] tx_dest,
    output logic [ID_W-1:0]   tx_id,
    output logic [PAY_W-1:0]  tx_payload
);

    logic lock_q, lock_d;
    logic sel_ack;

    always_comb begin
        sel_ack   = ack_valid && !(lock_q && dat_valid);
        tx_valid  = ack_valid || dat_valid;
        tx_kind   = sel_ack ? KIND_ACK : KIND_DATA;
        tx_dest   = sel_ack ? ack_dest : dat_dest;
        tx_id     = sel_ack ? ack_id : dat_id;
        tx_payload = sel_ack ? '0 : dat_payload;
        ack_grant = sel_ack && tx_ready;
        dat_grant = dat_valid && !sel_ack && tx_ready;
        lock_d    = dat_valid && !sel_ack && !tx_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_d;
        end
    end

endmodule

// File: rtl/parl_link_ctrl.sv
module parl_link_ctrl
    import parl_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 16,
    parameter int RTY_W  = 4,
    parameter int GAP_W  = 6,
    parameter int TMO_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_dest,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_bcast,
    input  logic [PAY_W-1:0]  req_payload,
    input  logic [RTY_W-1:0]  req_retries,
    input  logic [GAP_W-1:0]  req_gap,
    input  logic [TMO_W-1:0]  cfg_ack_timeout,
    output logic              done_valid,
    output logic              done_err,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_kind,
    output logic [ADDR_W-1:0] tx_dest,
    output logic [ID_W-1:0]   tx_id,
    output logic [PAY_W-1:0]  tx_payload,
    input  logic              rx_valid,
    input  logic              rx_kind,
    input  logic [ADDR_W-1:0] rx_src,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [PAY_W-1:0]  rx_payload,
    output logic              dlv_valid,
    output logic [ADDR_W-1:0] dlv_src,
    output logic [ID_W-1:0]   dlv_id,
    output logic [PAY_W-1:0]  dlv_payload
);

    logic              s_dat_valid, s_dat_grant;
    logic [ADDR_W-1:0] s_dat_dest;
    logic [ID_W-1:0]   s_dat_id;
    logic [PAY_W-1:0]  s_dat_payload;
    logic              r_ack_valid, r_ack_grant;
    logic [ADDR_W-1:0] r_ack_dest;
    logic [ID_W-1:0]   r_ack_id;
    logic              rx_is_ack, rx_is_data;

    assign rx_is_ack  = rx_valid && (rx_kind == KIND_ACK);
    assign rx_is_data = rx_valid && (rx_kind == KIND_DATA);

    parl_sender #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W),
        .RTY_W(RTY_W), .GAP_W(GAP_W), .TMO_W(TMO_W)
    ) u_snd (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_dest   (req_dest),
        .req_id     (req_id),
        .req_bcast  (req_bcast),
        .req_payload(req_payload),
        .req_retries(req_retries),
        .req_gap    (req_gap),
        .cfg_timeout(cfg_ack_timeout),
        .ack_valid  (rx_is_ack),
        .ack_src    (rx_src),
        .ack_id     (rx_id),
        .dat_valid  (s_dat_valid),
        .dat_grant  (s_dat_grant),
        .dat_dest   (s_dat_dest),
        .dat_id     (s_dat_id),
        .dat_payload(s_dat_payload),
        .done_valid (done_valid),
        .done_err   (done_err)
    );

    parl_receiver #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W)
    ) u_rcv (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (rx_is_data),
        .frm_src    (rx_src),
        .frm_id     (rx_id),
        .frm_payload(rx_payload),
        .ack_valid  (r_ack_valid),
        .ack_grant  (r_ack_grant),
        .ack_dest   (r_ack_dest),
        .ack_id     (r_ack_id),
        .dlv_valid  (dlv_valid),
        .dlv_src    (dlv_src),
        .dlv_id     (dlv_id),
        .dlv_payload(dlv_payload)
    );

    parl_tx_arb #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_valid  (r_ack_valid),
        .ack_dest   (r_ack_dest),
        .ack_id     (r_ack_id),
        .ack_grant  (r_ack_grant),
        .dat_valid  (s_dat_valid),
        .dat_dest   (s_dat_dest),
        .dat_id     (s_dat_id),
        .dat_payload(s_dat_payload),
        .dat_grant  (s_dat_grant),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_kind    (tx_kind),
        .tx_dest    (tx_dest),
        .tx_id      (tx_id),
        .tx_payload (tx_payload)
    );

endmodule

// File: rtl/parl_link_chk.sv
module parl_link_chk
    import parl_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done_valid,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_kind,
    input logic [ADDR_W-1:0] tx_dest,
    input logic [ID_W-1:0]   tx_id,
    input logic [PAY_W-1:0]  tx_payload,
    input logic              rx_valid,
    input logic              rx_kind,
    input logic [ADDR_W-1:0] rx_src,
    input logic [ID_W-1:0]   rx_id,
    input logic              dlv_valid,
    input logic [ADDR_W-1:0] dlv_src,
    input logic [ID_W-1:0]   dlv_id
);

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(!req_ready)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R2

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_kind) && $stable(tx_dest)
                                     && $stable(tx_id) && $stable(tx_payload))); // R3

    AST_DLV_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ($past(rx_valid && (rx_kind == KIND_DATA))
                       && dlv_src == $past(rx_src) && dlv_id == $past(rx_id))); // R10

endmodule

bind parl_link_ctrl parl_link_chk #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done_valid(done_valid),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_kind   (tx_kind),
    .tx_dest   (tx_dest),
    .tx_id     (tx_id),
    .tx_payload(tx_payload),
    .rx_valid  (rx_valid),
    .rx_kind   (rx_kind),
    .rx_src    (rx_src),
    .rx_id     (rx_id),
    .dlv_valid (dlv_valid),
    .dlv_src   (dlv_src),
    .dlv_id    (dlv_id)
);

// File: tb/tb_parl_link_ctrl.sv
`timescale 1ns/1ps
module tb_parl_link_ctrl;

    localparam int ID_W = 8, ADDR_W = 3, PAY_W = 16, RTY_W = 4, GAP_W = 6, TMO_W = 6;
    localparam int NODES = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_bcast = 0;
    logic [ADDR_W-1:0] req_dest = '0;
    logic [ID_W-1:0] req_id = '0;
    logic [PAY_W-1:0] req_payload = '0;
    logic [RTY_W-1:0] req_retries = '0;
    logic [GAP_W-1:0] req_gap = '0;
    logic [TMO_W-1:0] cfg_ack_timeout = 6'd5;
    logic req_ready, done_valid, done_err;
    logic tx_valid, tx_kind;
    logic tx_ready = 1'b1;
    logic [ADDR_W-1:0] tx_dest;
    logic [ID_W-1:0] tx_id;
    logic [PAY_W-1:0] tx_payload;
    logic rx_valid = 0, rx_kind = 0;
    logic [ADDR_W-1:0] rx_src = '0;
    logic [ID_W-1:0] rx_id = '0;
    logic [PAY_W-1:0] rx_payload = '0;
    logic dlv_valid;
    logic [ADDR_W-1:0] dlv_src;
    logic [ID_W-1:0] dlv_id;
    logic [PAY_W-1:0] dlv_payload;

    int n_tests = 0, n_fail = 0;
    bit exp_seen [NODES];
    int exp_last [NODES];

    always #4 clk = ~clk;

    parl_link_ctrl #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W),
        .RTY_W(RTY_W), .GAP_W(GAP_W), .TMO_W(TMO_W)
    ) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_attempts(input bit bc, input int rty, input logic [7:0] mask,
                                        output bit err);
        err = 1'b0;
        if (bc) return 1;
        for (int k = 0; k <= rty; k++) if (mask[k]) return k + 1;
        err = 1'b1;
        return rty + 1;
    endfunction

    task automatic run_send(input int dest, input int id, input bit bc, input int rty,
                            input int gap, input int tmo, input logic [7:0] mask,
                            input bit bad, input bit stall);
        int attempts = 0, last_hs = -1000, cyc = 0, ack_at = -1, bad_at = -1;
        bit busy_ok = 1, fields_ok = 1, space_ok = 1, got = 0, err_seen = 0, eerr;
        int eatt;
        logic [PAY_W-1:0] pay = PAY_W'($urandom);
        @(negedge clk);
        cfg_ack_timeout = TMO_W'(tmo);
        chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid = 1; req_dest = ADDR_W'(dest); req_id = ID_W'(id); req_bcast = bc;
        req_payload = pay; req_retries = RTY_W'(rty); req_gap = GAP_W'(gap);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 3000; i++) begin
            if (i > 0) @(negedge clk);
            cyc++;
            if (done_valid) begin got = 1; err_seen = done_err; break; end
            if (req_ready) busy_ok = 0;
            rx_valid = 0;
            if (cyc == bad_at) begin
                rx_valid = 1; rx_kind = 1;
                rx_src = (cyc % 2) ? ADDR_W'(dest) : ADDR_W'(dest ^ 1);
                rx_id  = (cyc % 2) ? ID_W'(id ^ 1) : ID_W'(id);
            end
            if (cyc == ack_at) begin
                rx_valid = 1; rx_kind = 1; rx_src = ADDR_W'(dest); rx_id = ID_W'(id);
            end
            tx_ready = stall ? ($urandom % 4 != 0) : 1'b1;
            if (tx_valid && tx_ready) begin
                attempts++;
                if (tx_kind != 0 || tx_dest != ADDR_W'(dest) || tx_id != ID_W'(id)
                    || tx_payload != pay) fields_ok = 0;
                if (attempts > 1 && (cyc - last_hs) < tmo + gap + 3) space_ok = 0;
                last_hs = cyc;
                if (!bc) begin
                    bad_at = bad ? cyc + 1 : -1;
                    ack_at = (attempts <= 8 && mask[attempts-1])
                             ? cyc + 2 + int'($urandom % (tmo - 1)) : -1;
                end
            end
        end
        rx_valid = 0; tx_ready = 1;
        eatt = exp_attempts(bc, rty, mask, eerr);
        chk(got, "R2", "completion seen", got, 1);
        chk(busy_ok, "R2", "ready stayed low while busy", busy_ok, 1);
        chk(fields_ok, "R3", "data frame fields", fields_ok, 1);
        chk(space_ok, "R8", "attempt spacing", space_ok, 1);
        if (bc) begin
            chk(attempts == 1, "R4", "broadcast attempts", attempts, 1);
            chk(err_seen == 0, "R4", "broadcast error flag", err_seen, 0);
        end else if (eerr) begin
            chk(attempts == eatt, "R7", "attempts before failure", attempts, eatt);
            chk(err_seen == 1, "R7", "failure flag", err_seen, 1);
        end else begin
            chk(attempts == eatt, bad ? "R6" : "R5", "attempts before ack", attempts, eatt);
            chk(err_seen == 0, "R5", "success flag", err_seen, 0);
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!tx_valid, bc ? "R4" : "R5", "channel quiet after completion", tx_valid, 0);
        end
    endtask

    task automatic rx_frame(input int src, input int id);
        logic [PAY_W-1:0] pay = PAY_W'($urandom);
        bit fresh;
        @(negedge clk);
        tx_ready = 1;
        rx_valid = 1; rx_kind = 0; rx_src = ADDR_W'(src); rx_id = ID_W'(id); rx_payload = pay;
        @(negedge clk);
        rx_valid = 0;
        fresh = !exp_seen[src] || exp_last[src] != id;
        chk(dlv_valid == fresh, "R10", "delivery decision", dlv_valid, fresh);
        if (fresh)
            chk(dlv_src == ADDR_W'(src) && dlv_id == ID_W'(id) && dlv_payload == pay,
                "R10", "delivered fields", dlv_id, id);
        exp_seen[src] = 1; exp_last[src] = id;
        chk(tx_valid && tx_kind == 1 && tx_dest == ADDR_W'(src) && tx_id == ID_W'(id),
            "R9", "acknowledgement frame", {tx_valid, tx_kind, tx_id}, {1'b1, 1'b1, ID_W'(id)});
        @(negedge clk);
        chk(!tx_valid, "R9", "single acknowledgement", tx_valid, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7211));
        for (int i = 0; i < NODES; i++) begin exp_seen[i] = 0; exp_last[i] = 0; end
        repeat (3) @(negedge clk);
        chk(req_ready && !tx_valid && !done_valid && !dlv_valid, "R1", "outputs in reset",
            {req_ready, tx_valid, done_valid, dlv_valid}, 4'b1000);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !tx_valid && !done_valid && !dlv_valid, "R1", "outputs after reset",
            {req_ready, tx_valid, done_valid, dlv_valid}, 4'b1000);

        // directed sender corners
        run_send(2, 10, 0, 0, 0, 4, 8'h00, 0, 0); // R7 no retry allowance
        run_send(3, 11, 0, 3, 0, 5, 8'h08, 0, 0); // R7 ack on last attempt, zero gap
        run_send(4, 12, 0, 2, 5, 6, 8'h01, 1, 0); // R6 wrong ack precedes right one
        run_send(5, 13, 1, 3, 2, 4, 8'h00, 0, 1); // R4 broadcast under stalls
        run_send(1, 14, 0, 3, 3, 4, 8'h00, 1, 1); // R6 only mismatched acks, R8 spacing

        for (int t = 0; t < 40; t++) begin
            logic [7:0] m = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            run_send(int'($urandom % NODES), int'($urandom % 256), ($urandom % 5 == 0),
                     int'($urandom % 4), int'($urandom % 6), 4 + int'($urandom % 7),
                     m, $urandom % 2, $urandom % 2);
        end

        // receiver: first frames, duplicates, independent sources
        rx_frame(0, 5);
        rx_frame(0, 5);   // R10 duplicate
        rx_frame(1, 5);   // R10 same id, other source
        rx_frame(0, 6);
        rx_frame(0, 5);   // R10 older id differs from last: delivered again
        for (int t = 0; t < 60; t++) rx_frame(int'($urandom % NODES), int'($urandom % 3));

        // R11: frame arriving while ack waits is dropped
        @(negedge clk);
        tx_ready = 0;
        rx_valid = 1; rx_kind = 0; rx_src = 3'd6; rx_id = 8'd50; rx_payload = 16'h1234;
        @(negedge clk);
        chk(dlv_valid, "R11", "first frame delivered", dlv_valid, 1);
        exp_seen[6] = 1; exp_last[6] = 50;
        rx_src = 3'd7; rx_id = 8'd60;
        @(negedge clk);
        rx_valid = 0;
        chk(!dlv_valid, "R11", "frame during pending ack not delivered", dlv_valid, 0);
        chk(tx_valid && tx_kind && tx_dest == 3'd6 && tx_id == 8'd50, "R11",
            "pending ack unchanged", tx_id, 50);
        tx_ready = 1;
        @(negedge clk);
        chk(!tx_valid, "R11", "no ack for dropped frame", tx_valid, 0);
        if (!exp_seen[7] || exp_last[7] != 60) begin
            rx_frame(7, 60);
        end else begin
            rx_frame(7, 61);
        end

        // R9: pending ack takes the channel before a new data frame
        @(negedge clk);
        cfg_ack_timeout = 6'd4;
        tx_ready = 0;
        rx_valid = 1; rx_kind = 0; rx_src = 3'd5; rx_id = 8'd99;
        @(negedge clk);
        rx_valid = 0;
        exp_seen[5] = 1; exp_last[5] = 99;
        req_valid = 1; req_dest = 3'd1; req_id = 8'd77; req_bcast = 0;
        req_retries = '0; req_gap = '0; req_payload = 16'hBEEF;
        @(negedge clk);
        req_valid = 0;
        chk(tx_valid && tx_kind == 1 && tx_id == 8'd99, "R9", "ack ahead of data",
            tx_kind, 1);
        tx_ready = 1;
        @(negedge clk);
        chk(tx_valid && tx_kind == 0 && tx_id == 8'd77, "R9", "data after ack", tx_kind, 0);
        begin
            bit seen_done = 0, e = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (done_valid) begin seen_done = 1; e = done_err; break; end
            end
            chk(seen_done && e, "R7", "unanswered request fails", e, 1);
        end

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule